// File: doc/BRIEF.md
# Serial Presence Detect Memory, Two-Wire Slave

This block presents a 256-byte memory-module description table over a two-wire serial bus (I2C). A host reads the table to learn the geometry and timing of a memory module, and may rewrite the descriptive bytes. The slave answers on the 7-bit address formed by a fixed 4-bit base followed by three strap inputs. Several modules can therefore share one bus.

The table contents come from parameters and are loaded at reset. Byte 63 holds no storage of its own. It is the low eight bits of the running sum of bytes 0 to 62, and a small accumulator keeps it current after every write into that range. The upper half of the space and bytes 126 and 127 always read back as all ones.

The bus pins are open drain. The block receives the sampled line levels and returns only a drive-low enable for the data line. Both lines are oversampled by the system clock through a synchroniser. One finite-state machine then tracks the transfer through these states:

- `ST_IDLE`: no transfer is in progress.
- `ST_DEV`: the device address byte is being received.
- `ST_DEV_ACK`: the device address is acknowledged.
- `ST_WORD`: the word address byte is being received.
- `ST_WORD_ACK`: the word address is acknowledged.
- `ST_WDATA`: a data byte is being received.
- `ST_WDATA_ACK`: the data byte is acknowledged.
- `ST_RDATA`: a data byte is being sent.
- `ST_RACK`: the master's acknowledge is being sampled.

The transitions are as follows:

- Start to address: a start condition moves any state to `ST_DEV`.
- Stop to idle: a stop condition moves any state to `ST_IDLE`.
- Address match: after eight bits, a matching address moves `ST_DEV` to `ST_DEV_ACK`. Any other address moves it back to `ST_IDLE`.
- Direction split: `ST_DEV_ACK` moves to `ST_RDATA` for a read, or to `ST_WORD` for a write.
- Write chain: `ST_WORD` moves through `ST_WORD_ACK` into `ST_WDATA`. From there the machine alternates between `ST_WDATA` and `ST_WDATA_ACK`.
- Read chain: `ST_RDATA` moves to `ST_RACK`. On a master acknowledge, `ST_RACK` returns to `ST_RDATA`. On a master not-acknowledge, it moves to `ST_IDLE`.

Top module: `spd_i2c_slave`

## Requirements
- R1: The slave acknowledges (pulls the data line low during the ninth clock) only the address whose upper four bits are 1010 and whose lower three bits equal `strap_i`. Any other address gets no acknowledge and no further drive until the next start.
- R2: In a write transfer (R/W bit 0), the slave acknowledges the word address and every data byte. Each data byte is stored at the current pointer.
- R3: The word pointer advances by one after each data byte written or read, and wraps from 255 to 0.
- R4: A repeated start keeps the pointer. A read transfer (R/W bit 1) that has no preceding word address starts at the current pointer.
- R5: In a read, the slave sends bits MSB first and continues byte after byte while the master acknowledges. After a master not-acknowledge, it releases the line and stays idle.
- R6: A read of byte 63 always returns the low 8 bits of the sum of bytes 0 to 62, including after writes into that range. Writes to byte 63 are ignored.
- R7: Bytes 126 to 255 always read FFh, and writes to them are ignored.
- R8: After reset, bytes 0 to 14 equal the parameter default 80,08,02,0C,0B,01,48,00,01,32,0D,02,00,08,08 (hex, byte 0 first). Bytes 15 to 61 read FFh, byte 62 reads 00h, and bytes 64 to 125 read A5h, so byte 63 reads 0Dh.
- R9: The data-line drive changes only while SCL is low. Data is sampled on rising SCL.
- R10: After reset, the data line is released and the pointer is 0.
- R11: A stop ends any transfer. A transfer abandoned after its address phase leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled level of the serial clock line |
| sda_i | input | 1 | Sampled level of the serial data line |
| strap_i | input | 3 | Low three bits of the slave address |
| sda_drive_low_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong state or bit counter shows up on the bus within one byte time. An acknowledge lands on the wrong clock, or read data comes out shifted by a bit, so the byte compares fail at once. A pointer that skips, repeats or fails to wrap shows up only on the next read, as data from a neighbouring address. The bench therefore always reads back across the region it has just written. A stale checksum accumulator shows no symptom until byte 63 is read. For that reason every random write phase is followed by a checksum read.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;
    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 8;
    localparam int DESC_LEN = 15;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } spd_state_e;
endpackage

// File: rtl/spd_line_sync.sv
`timescale 1ns/1ps
module spd_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= RESET_VAL;
                else        pipe <= line_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= {STAGES{RESET_VAL}};
                else        pipe <= {pipe[STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= RESET_VAL;
        else        prev_o <= pipe[STAGES-1];
    end

    assign level_o = pipe[STAGES-1];
endmodule

// File: rtl/spd_store.sv
`timescale 1ns/1ps
module spd_store import spd_pkg::*; #(
    parameter logic [8*DESC_LEN-1:0] DESC_BYTES  = '0,
    parameter logic [7:0]            REV_CODE    = 8'h00,
    parameter logic [7:0]            VENDOR_FILL = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_data
);
    localparam int DEPTH     = 128;
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int SUM_IDX   = 63;
    localparam int REV_IDX   = 62;
    localparam int VEND_LO   = 64;
    localparam int VEND_HI   = 125;

    function automatic logic [7:0] init_byte(input int i);
        if (i < DESC_LEN)                    return DESC_BYTES[8*i +: 8];
        else if (i == REV_IDX)               return REV_CODE;
        else if (i >= VEND_LO && i <= VEND_HI) return VENDOR_FILL;
        else                                 return 8'hFF;
    endfunction

    function automatic logic [7:0] init_sum();
        logic [7:0] acc = '0;
        for (int i = 0; i < SUM_IDX; i++) acc = acc + init_byte(i);
        return acc;
    endfunction

    logic [7:0]       mem [DEPTH];
    logic [7:0]       csum;
    logic [IDX_W-1:0] widx;
    logic             writable;

    assign widx     = wr_addr[IDX_W-1:0];
    assign writable = (wr_addr <= PTR_W'(VEND_HI)) && (wr_addr != PTR_W'(SUM_IDX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_byte(i);
            csum <= init_sum();
        end else if (wr_en && writable) begin
            mem[widx] <= wr_data;
            if (wr_addr < PTR_W'(SUM_IDX))
                csum <= csum - mem[widx] + wr_data;
        end
    end

    always_comb begin
        if (rd_addr == PTR_W'(SUM_IDX))      rd_data = csum;
        else if (rd_addr <= PTR_W'(VEND_HI)) rd_data = mem[rd_addr[IDX_W-1:0]];
        else                                 rd_data = 8'hFF;
    end

    logic [7:0] full_sum;
    always_comb begin
        full_sum = '0;
        for (int i = 0; i < SUM_IDX; i++) full_sum = full_sum + mem[i];
    end

    // R6
    csum_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum == full_sum);
endmodule

// File: rtl/spd_i2c_slave.sv
`timescale 1ns/1ps
module spd_i2c_slave import spd_pkg::*; #(
    parameter logic [3:0]            DEV_BASE    = 4'b1010,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [8*DESC_LEN-1:0] DESC_BYTES  = {8'h08, 8'h08, 8'h00, 8'h02, 8'h0D,
                                                    8'h32, 8'h01, 8'h00, 8'h48, 8'h01,
                                                    8'h0B, 8'h0C, 8'h02, 8'h08, 8'h80},
    parameter logic [7:0]            REV_CODE    = 8'h00,
    parameter logic [7:0]            VENDOR_FILL = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_drive_low_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic scl_s, scl_p, sda_s, sda_p;

    spd_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .level_o(scl_s), .prev_o(scl_p));
    spd_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .level_o(sda_s), .prev_o(sda_p));

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

    spd_state_e       state, state_n;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg, tx;
    logic [PTR_W-1:0] ptr;
    logic             rw_q, nack_q, drive_q;
    logic             byte_done, dev_match, st_wr;
    logic [7:0]       rd_data;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign dev_match = (shreg[7:1] == {DEV_BASE, strap_i});
    assign st_wr     = (state == ST_WDATA) && byte_done;

    spd_store #(.DESC_BYTES(DESC_BYTES), .REV_CODE(REV_CODE), .VENDOR_FILL(VENDOR_FILL)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(st_wr), .wr_addr(ptr), .wr_data(shreg),
        .rd_addr(ptr), .rd_data(rd_data));

    always_comb begin
        state_n = state;
        if (start_ev)     state_n = ST_DEV;
        else if (stop_ev) state_n = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:      state_n = ST_IDLE;
                ST_DEV:       if (byte_done) state_n = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall)  state_n = rw_q ? ST_RDATA : ST_WORD;
                ST_WORD:      if (byte_done) state_n = ST_WORD_ACK;
                ST_WORD_ACK:  if (scl_fall)  state_n = ST_WDATA;
                ST_WDATA:     if (byte_done) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_n = ST_WDATA;
                ST_RDATA:     if (byte_done) state_n = ST_RACK;
                ST_RACK:      if (scl_fall)  state_n = nack_q ? ST_IDLE : ST_RDATA;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            drive_q <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bit_cnt <= '0;
            drive_q <= 1'b0;
        end else begin
            unique case (state)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        drive_q <= (state != ST_DEV) || dev_match;
                        if (state == ST_DEV)   rw_q <= shreg[0];
                        if (state == ST_WORD)  ptr  <= shreg;
                        if (state == ST_WDATA) ptr  <= ptr + 1'b1;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        tx      <= rd_data;
                        drive_q <= rw_q & ~rd_data[7];
                    end
                end
                ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        drive_q <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                    if (byte_done) begin
                        bit_cnt <= '0;
                        drive_q <= 1'b0;
                        ptr     <= ptr + 1'b1;
                    end else if (scl_fall) begin
                        tx      <= {tx[BYTE_W-2:0], 1'b0};
                        drive_q <= ~tx[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    if (scl_fall && !nack_q) begin
                        bit_cnt <= '0;
                        tx      <= rd_data;
                        drive_q <= ~rd_data[7];
                    end
                end
                default: drive_q <= 1'b0;
            endcase
        end
    end

    assign sda_drive_low_o = drive_q;

    // R9
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(drive_q));

    // R1
    dev_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (shreg[7:1] == {DEV_BASE, strap_i}));

    // R5
    drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q |-> (state inside {ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK, ST_RDATA}));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && $past(state) == ST_WDATA) |-> (ptr == $past(ptr) + 8'd1));
endmodule

// File: tb/spd_i2c_slave_bench.sv
`timescale 1ns/1ps
module spd_i2c_slave_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b011;
    logic       drive;
    logic       sda_line;

    assign sda_line = sda_m & ~drive;

    always #2.5 clk = ~clk;

    spd_i2c_slave u_spd_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(strap), .sda_drive_low_o(drive));

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    int r9_viol = 0;

    logic [7:0] ref_mem [256];
    logic [7:0] mptr;

    function automatic logic [7:0] ref_init(input int i);
        logic [7:0] d [15] = '{8'h80, 8'h08, 8'h02, 8'h0C, 8'h0B, 8'h01, 8'h48, 8'h00,
                               8'h01, 8'h32, 8'h0D, 8'h02, 8'h00, 8'h08, 8'h08};
        if (i < 15)                return d[i];
        if (i == 62)               return 8'h00;
        if (i >= 64 && i <= 125)   return 8'hA5;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        logic [7:0] s = '0;
        if (a == 8'd63) begin
            for (int i = 0; i < 63; i++) s = s + ref_mem[i];
            return s;
        end
        return ref_mem[a];
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
        if (a <= 8'd125 && a != 8'd63) ref_mem[a] = d;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin : r9_mon
        logic ps, pd;
        if (rst_n && ps && scl && (drive !== pd)) r9_viol++;
        ps = scl;
        pd = drive;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        tick(Q);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            b = {b[6:0], s};
        end
        bit_io(~master_ack, s);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] d [8]);
        logic ack;
        bus_start();
        send_byte(dev(1'b0), ack); check("R1 dev ack (write)", ack, 1'b1);
        send_byte(a, ack);         check("R2 word ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);  check("R2 data ack", ack, 1'b1);
            model_wr(a + 8'(i), d[i]);
        end
        bus_stop();
        mptr = a + 8'(n);
    endtask

    task automatic read_run(input logic [7:0] a, input int n, input string tag);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check(tag, b, model_rd(a + 8'(i)));
        end
        bus_stop();
        mptr = a + 8'(n);
    endtask

    task automatic read_seq(input logic [7:0] a, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(dev(1'b0), ack); check("R1 dev ack", ack, 1'b1);
        send_byte(a, ack);         check("R2 word ack", ack, 1'b1);
        bus_start();
        send_byte(dev(1'b1), ack); check("R4 dev ack after repeated start", ack, 1'b1);
        read_run(a, n, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        logic [7:0] a;
        a = mptr;
        bus_start();
        send_byte(dev(1'b1), ack); check("R4 dev ack current read", ack, 1'b1);
        read_run(a, n, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] d [8];
        for (int i = 0; i < 256; i++) ref_mem[i] = ref_init(i);
        mptr = 8'd0;
        void'($urandom(32'd2024));

        tick(8);
        rst_n = 1'b1;
        tick(4);
        // R10: line released after reset, pointer at 0
        check("R10 drive after reset", drive, 1'b0);
        cur_read(1, "R10 pointer after reset");

        // R8 defaults and R6 checksum
        read_seq(8'd0, 3, "R8 defaults bytes 0-2");
        read_seq(8'd6, 1, "R8 default byte 6");
        read_seq(8'd11, 1, "R8 default byte 11");
        read_seq(8'd63, 1, "R6 default checksum");
        check("R8 checksum 0Dh", model_rd(8'd63), 8'h0D);
        read_seq(8'd30, 1, "R8 undefined reads FF");
        read_seq(8'd100, 1, "R8 vendor fill");

        // R1: wrong address (strap and base) NACK
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ack); check("R1 strap mismatch nack", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, strap, 1'b1}, ack); check("R1 base mismatch nack", ack, 1'b0);
        bus_stop();

        // R2/R6: writes into checksum range, write to 63 ignored
        d = '{8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        write_seq(8'd20, 3, d);
        read_seq(8'd20, 3, "R2 written bytes");
        read_seq(8'd63, 1, "R6 checksum after write");
        d[0] = 8'h77;
        write_seq(8'd63, 1, d);
        read_seq(8'd62, 2, "R6 write to 63 ignored");

        // R7: high region ignores writes
        d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00};
        write_seq(8'd125, 4, d);
        read_seq(8'd125, 4, "R7 high region FF");

        // R3: wrap from 255 to 0, sequential read and pointer
        read_seq(8'd254, 4, "R3 wrap read");
        cur_read(2, "R3 pointer after wrap");

        // R11: abort after address phase keeps pointer
        bus_start();
        send_byte(dev(1'b0), ack); check("R11 dev ack", ack, 1'b1);
        bus_stop();
        cur_read(1, "R11 pointer kept");

        // R1: new strap value
        strap = 3'b101;
        tick(4);
        read_seq(8'd1, 2, "R1 new strap");
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b1}, ack); check("R1 old strap nack", ack, 1'b0);
        bus_stop();
        // R5: slave released after final NACK
        check("R5 released after read", drive, 1'b0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int op;
            int n;
            logic [7:0] a;
            op = int'($urandom % 3);
            n  = 1 + int'($urandom % 4);
            a  = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 70);
            if (op == 0) begin
                for (int k = 0; k < 8; k++) d[k] = 8'($urandom);
                write_seq(a, n, d);
                read_seq(8'd63, 1, "R6 random checksum");
            end else if (op == 1) begin
                read_seq(a, n, "R2 random read");
            end else begin
                cur_read(n, "R4 random current read");
            end
        end

        check("R9 drive stable while SCL high", r9_viol, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule